// File: doc/BRIEF.md
# Wrapped-Order Line Fill Controller

This block handles one cache-line refill at a time after a miss. It takes the word address that missed and sends one memory request per word of the line. The first request is for the missed word. The order then wraps modulo the line length, so the last request is for the word just below the missed one. Memory answers with one beat per request, in the order the requests were sent.

The first returning beat is the word the processor is waiting for. It is forwarded on a one-cycle restart strobe in the same cycle it arrives, so the processor can resume before the line is complete. The remaining beats land in a line buffer while the processor runs. The processor may read any word of the buffer that has already landed; a read of a word still in flight is held off. One cycle after the final beat, a completion pulse presents the assembled line for the host cache to store. A new miss is refused until that pulse has passed.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: `miss_ready` is high whenever no fill is in progress, and a miss is taken on a clock edge where `miss_valid` and `miss_ready` are both high.
- R2: For a miss at word address A, exactly WORDS requests are issued. Request k (k = 0 upward) carries the upper bits of A with the low log2(WORDS) bits replaced by (A mod WORDS + k) mod WORDS.
- R3: When the missed word sits at offset 0 of its line, the requests run in plain ascending order 0, 1, 2, 3.
- R4: `restart_valid` is high in exactly the cycle of the first response beat after a miss, and `restart_data` then equals that beat's data.
- R5: Response beat k is stored at line slot (A mod WORDS + k) mod WORDS. In `line_data`, slot i occupies bits [i*64 +: 64].
- R6: `line_done` is a single-cycle pulse in the cycle after the final beat, with the full line on `line_data` in that cycle.
- R7: From the acceptance of a miss through the `line_done` cycle, `miss_ready` is low and `miss_valid` has no effect: it produces no extra requests.
- R8: `rd_ready` is low for a slot whose beat has not yet been written, including the cycle in which that beat arrives. From the next cycle on, `rd_ready` is high and `rd_data` holds the slot's word. This holds for every slot, and the line stays readable after completion until the next miss.
- R9: After reset there are no requests, no restart, no completion, `miss_ready` is high and no slot is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request from the cache |
| miss_addr | input | ADDR_W | Word address that missed |
| miss_ready | output | 1 | Controller idle, miss can be taken |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response beat, in request order |
| mem_rsp_data | input | DATA_W | Response word |
| restart_valid | output | 1 | Missed word delivered to the processor |
| restart_data | output | DATA_W | The missed word |
| rd_valid | input | 1 | Processor read of the partial line |
| rd_word | input | log2(WORDS) | Slot the processor reads |
| rd_ready | output | 1 | Read served this cycle |
| rd_data | output | DATA_W | Word of the read slot |
| line_done | output | 1 | Line complete pulse |
| line_data | output | WORDS*DATA_W | Assembled line |

## Verification
A background fill write and a processor read of the partial buffer can fall in the same cycle, and they can target the same slot. The bench stalls the memory with a credit scheme, points a read at the missed word, and then releases exactly one beat. It expects the read to be refused in the cycle the beat lands and served with the right word in the cycle after. Reads of slots that have not arrived must stay refused throughout.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_st_e;

  // slot reached after 'step' beats from the missed slot; words is a power of two
  function automatic int unsigned wrap_slot(int unsigned crit, int unsigned step,
                                            int unsigned words);
    return (crit + step) & (words - 1);
  endfunction

endpackage

// File: rtl/cwf_addr_gen.sv
module cwf_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int CNT_W = IDX_W + 1;

  logic [ADDR_W-IDX_W-1:0] base_q;
  logic [IDX_W-1:0]        crit_q;
  logic [CNT_W-1:0]        sent_q;
  logic [IDX_W-1:0]        slot;
  logic                    req_fire;

  assign req_valid = (sent_q != CNT_W'(WORDS));
  assign req_fire  = req_valid && req_ready;
  assign slot      = IDX_W'(cwf_pkg::wrap_slot(int'(crit_q), int'(sent_q), WORDS));
  assign req_addr  = {base_q, slot};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      crit_q <= '0;
      sent_q <= CNT_W'(WORDS);
    end else if (start) begin
      base_q <= start_addr[ADDR_W-1:IDX_W];
      crit_q <= start_addr[IDX_W-1:0];
      sent_q <= '0;
    end else if (req_fire) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  AST_START_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !req_valid); // R2

endmodule

// File: rtl/cwf_line_asm.sv
module cwf_line_asm #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      wr_en,
  input  logic [$clog2(WORDS)-1:0]  wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [$clog2(WORDS)-1:0]  rd_word,
  output logic                      rd_hit,
  output logic [DATA_W-1:0]         rd_data,
  output logic [WORDS-1:0]          arrived,
  output logic [WORDS*DATA_W-1:0]   line_flat
);
  localparam int IDX_W = $clog2(WORDS);

  for (genvar s = 0; s < WORDS; s++) begin : g_slot
    logic [DATA_W-1:0] word_q;
    logic              got_q;
    logic              hit_s;

    assign hit_s = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        got_q  <= 1'b0;
      end else if (clear) begin
        got_q  <= 1'b0;
      end else if (hit_s) begin
        word_q <= wr_data;
        got_q  <= 1'b1;
      end
    end

    assign arrived[s]                    = got_q;
    assign line_flat[s*DATA_W +: DATA_W] = word_q;
  end

  assign rd_hit  = arrived[rd_word];
  assign rd_data = line_flat[rd_word*DATA_W +: DATA_W];

  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> !(wr_en && wr_idx == rd_word)); // R8

endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_valid,
  input  logic [ADDR_W-1:0]         miss_addr,
  output logic                      miss_ready,
  output logic                      mem_req_valid,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_req_ready,
  input  logic                      mem_rsp_valid,
  input  logic [DATA_W-1:0]         mem_rsp_data,
  output logic                      restart_valid,
  output logic [DATA_W-1:0]         restart_data,
  input  logic                      rd_valid,
  input  logic [$clog2(WORDS)-1:0]  rd_word,
  output logic                      rd_ready,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      line_done,
  output logic [WORDS*DATA_W-1:0]   line_data
);
  import cwf_pkg::*;

  localparam int IDX_W = $clog2(WORDS);
  localparam int CNT_W = IDX_W + 1;

  fill_st_e          state_q;
  logic [IDX_W-1:0]  crit_q;
  logic [CNT_W-1:0]  rcv_q;

  logic              miss_fire;
  logic              beat_wr;
  logic              last_beat;
  logic [IDX_W-1:0]  beat_slot;
  logic              rd_hit;
  logic [WORDS-1:0]  arrived;

  assign miss_ready = (state_q == ST_IDLE);
  assign miss_fire  = miss_valid && miss_ready;
  assign beat_wr    = (state_q == ST_FILL) && mem_rsp_valid;
  assign last_beat  = beat_wr && (rcv_q == CNT_W'(WORDS - 1));
  assign beat_slot  = IDX_W'(wrap_slot(int'(crit_q), int'(rcv_q), WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      crit_q  <= '0;
      rcv_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_fire) begin
          state_q <= ST_FILL;
          crit_q  <= miss_addr[IDX_W-1:0];
          rcv_q   <= '0;
        end
        ST_FILL: if (beat_wr) begin
          rcv_q <= rcv_q + 1'b1;
          if (last_beat) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign restart_valid = beat_wr && (rcv_q == '0);
  assign restart_data  = mem_rsp_data;
  assign line_done     = (state_q == ST_DONE);
  assign rd_ready      = rd_valid && rd_hit;

  cwf_addr_gen #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (miss_fire),
    .start_addr (miss_addr),
    .req_ready  (mem_req_ready),
    .req_valid  (mem_req_valid),
    .req_addr   (mem_req_addr)
  );

  cwf_line_asm #(.DATA_W(DATA_W), .WORDS(WORDS)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (miss_fire),
    .wr_en     (beat_wr),
    .wr_idx    (beat_slot),
    .wr_data   (mem_rsp_data),
    .rd_word   (rd_word),
    .rd_hit    (rd_hit),
    .rd_data   (rd_data),
    .arrived   (arrived),
    .line_flat (line_data)
  );

  AST_MISS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !miss_ready); // R7
  AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !mem_req_valid); // R7
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (&arrived)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done); // R6
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> !restart_valid); // R4

endmodule

// File: tb/sim_cwf_fill_ctrl.sv
module sim_cwf_fill_ctrl;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           miss_valid = 1'b0;
  logic [AW-1:0]  miss_addr = '0;
  logic           miss_ready;
  logic           mem_req_valid;
  logic [AW-1:0]  mem_req_addr;
  logic           mem_req_ready = 1'b0;
  logic           mem_rsp_valid = 1'b0;
  logic [DW-1:0]  mem_rsp_data = '0;
  logic           restart_valid;
  logic [DW-1:0]  restart_data;
  logic           rd_valid = 1'b0;
  logic [IW-1:0]  rd_word = '0;
  logic           rd_ready;
  logic [DW-1:0]  rd_data;
  logic           line_done;
  logic [NW*DW-1:0] line_data;

  cwf_fill_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [NW*DW-1:0] act,
                     logic [NW*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memfn(logic [AW-1:0] a);
    return {a ^ 32'h5A5A_0F0F, a + 32'h1357_9BDF};
  endfunction

  // scoreboard queues
  logic [AW-1:0]    exp_addr[$];
  logic [DW-1:0]    exp_rst[$];
  logic [NW*DW-1:0] exp_line[$];
  logic [AW-1:0]    mem_q[$];
  string            addr_tag = "R2";

  // memory model
  int cyc = 0;
  int rsp_credit = 0;
  bit rsp_free = 1'b1;
  bit gap_mode = 1'b0;
  bit rdy_alt = 1'b0;

  always @(posedge clk) begin
    cyc++;
    #1;
    mem_req_ready = rdy_alt ? (cyc % 2 == 0) : 1'b1;
    if (mem_q.size() > 0 && (rsp_free || rsp_credit > 0) && !(gap_mode && cyc % 3 == 1)) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = memfn(mem_q.pop_front());
      if (!rsp_free) rsp_credit--;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
    end
  end

  // monitor
  int beat = 0;
  bit last_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (miss_valid && miss_ready) beat = 0;
      if (mem_req_valid && mem_req_ready) begin
        mem_q.push_back(mem_req_addr);
        if (exp_addr.size() == 0)
          chk(1'b0, addr_tag, "unexpected request", mem_req_addr, 0);
        else begin
          logic [AW-1:0] e;
          e = exp_addr.pop_front();
          chk(mem_req_addr == e, addr_tag, "wrap-order request address", mem_req_addr, e);
        end
      end
      if (mem_rsp_valid || restart_valid) begin
        chk(restart_valid == (mem_rsp_valid && beat == 0), "R4", "restart on first beat only",
            restart_valid, (mem_rsp_valid && beat == 0));
        if (restart_valid) begin
          logic [DW-1:0] e;
          e = (exp_rst.size() > 0) ? exp_rst.pop_front() : '0;
          chk(restart_data == e, "R4", "restart data", restart_data, e);
        end
      end
      if (line_done || last_prev)
        chk(line_done == last_prev, "R6", "done one cycle after last beat", line_done, last_prev);
      if (line_done) begin
        logic [NW*DW-1:0] e;
        e = (exp_line.size() > 0) ? exp_line.pop_front() : '0;
        chk(line_data == e, "R5", "assembled line", line_data, e);
        chk(!miss_ready, "R7", "miss refused in done cycle", miss_ready, 0);
      end
      last_prev = mem_rsp_valid && beat == NW - 1;
      if (mem_rsp_valid) beat++;
    end
  end

  task automatic start_miss(logic [AW-1:0] a);
    logic [NW*DW-1:0] ln;
    for (int k = 0; k < NW; k++)
      exp_addr.push_back({a[AW-1:IW], IW'((a % NW + k) % NW)});
    for (int i = 0; i < NW; i++)
      ln[i*DW +: DW] = memfn({a[AW-1:IW], IW'(i)});
    exp_rst.push_back(memfn(a));
    exp_line.push_back(ln);
    @(posedge clk); #1;
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    chk(miss_ready, "R1", "idle controller takes miss", miss_ready, 1);
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!line_done);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd_valid = 1'b1;
    rd_word  = 2'd0;
    @(negedge clk);
    // R9 reset state
    chk(miss_ready, "R9", "miss_ready after reset", miss_ready, 1);
    chk(!mem_req_valid, "R9", "no request after reset", mem_req_valid, 0);
    chk(!restart_valid && !line_done, "R9", "no restart/done after reset",
        {restart_valid, line_done}, 0);
    chk(!rd_ready, "R9", "no readable slot after reset", rd_ready, 0);
    @(posedge clk); #1 rd_valid = 1'b0;

    // R3: missed word at offset 0
    addr_tag = "R3";
    start_miss(32'h0000_0100);
    wait_done();
    addr_tag = "R2";

    // R2 wrap orders with stalls and gaps
    rdy_alt = 1'b1;
    gap_mode = 1'b1;
    start_miss(32'h0000_2222);
    wait_done();
    start_miss(32'h0000_3337);
    wait_done();
    rdy_alt = 1'b0;
    start_miss(32'hABCD_0005);
    wait_done();
    gap_mode = 1'b0;

    // R7: miss_valid held during a fill is ignored
    start_miss(32'h0000_4442);
    @(posedge clk); #1;
    miss_valid = 1'b1;
    miss_addr  = 32'hDEAD_BEE1;
    do begin
      @(negedge clk);
      chk(!miss_ready, "R7", "miss refused while filling", miss_ready, 0);
    end while (!line_done);
    @(posedge clk); #1 miss_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_addr.size() == 0 && mem_q.size() == 0, "R7", "no requests from refused miss",
        exp_addr.size(), 0);
    chk(miss_ready, "R1", "ready again after done", miss_ready, 1);

    // R8: reads of the partial line, and read/write in the same cycle
    rsp_free = 1'b0;
    rsp_credit = 0;
    start_miss(32'h0000_5551);
    repeat (6) @(negedge clk);
    @(posedge clk); #1;
    rd_valid = 1'b1;
    rd_word  = 2'd1;
    @(negedge clk);
    chk(!rd_ready, "R8", "missed slot not yet arrived", rd_ready, 0);
    rsp_credit = 1;
    @(negedge clk);
    chk(mem_rsp_valid && !rd_ready, "R8", "read refused in cycle of its beat",
        {mem_rsp_valid, rd_ready}, 2'b10);
    @(negedge clk);
    chk(rd_ready && rd_data == memfn(32'h0000_5551), "R8", "read served after beat",
        rd_data, memfn(32'h0000_5551));
    @(posedge clk); #1 rd_word = 2'd2;
    @(negedge clk);
    chk(!rd_ready, "R8", "later slot still stalled", rd_ready, 0);
    rsp_free = 1'b1;
    wait_done();
    @(posedge clk); #1 rd_word = 2'd0;
    @(negedge clk);
    chk(rd_ready && rd_data == memfn(32'h0000_5550), "R8", "wrapped slot readable after done",
        rd_data, memfn(32'h0000_5550));
    @(posedge clk); #1 rd_word = 2'd3;
    @(negedge clk);
    chk(rd_ready && rd_data == memfn(32'h0000_5553), "R5", "slot 3 holds its own word",
        rd_data, memfn(32'h0000_5553));
    @(posedge clk); #1 rd_valid = 1'b0;

    repeat (3) @(negedge clk);
    chk(exp_addr.size() == 0 && exp_rst.size() == 0 && exp_line.size() == 0, "R2",
        "scoreboard drained", exp_addr.size() + exp_rst.size() + exp_line.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule